// File: doc/BRIEF.md
# JTAG Debug-Bus Transport Register

This block is the target-side data register pair of a JTAG debug transport. It sits behind a TAP controller whose states reach it as single-cycle capture, shift and update strobes, together with the current instruction code. One instruction selects a 32-bit read-only identification word. A second instruction selects a debug-bus access register. That register carries a 2-bit operation, a 34-bit data word and an address.

On an update, the access register turns the shifted-in operation into a request on a simple valid/ready debug-bus port. On the following capture, it returns the status and data of the previous request. The host therefore works in a pipeline. A read requested in one scan delivers its data in the next scan. If a read or write arrives while an earlier request is still outstanding, the block drops it and reports busy. The host then repeats the same scan until the result is no longer busy.

Top module: `dbg_xport_reg`

## Requirements
- R1: With instruction code 0x10 selected, a capture loads a 32-bit word. Its bits 7:4 hold the bus address width and bits 3:0 hold the version. With the defaults (ABITS=6, VERSION=1) the word is 0x00000061.
- R2: With instruction code 0x11 selected, the access register is ABITS+36 bits long. The layout is op in bits 1:0, data in bits 35:2 and address in bits ABITS+35:36. It shifts least significant bit first on tdo, and tdi enters at the top bit. On capture, the address field holds the address of the last accepted request.
- R3: An update with op 1 (read) issues a bus read. The data returned appears in the data field of the next scan, with result code 0 (success).
- R4: An update with op 2 (write) issues a bus write of the full 34-bit data word, including flag bits 33 and 32. The write does not change the captured data field.
- R5: A read, write or conditional write that is updated while a request is still outstanding is dropped and issues nothing. The next capture reports result 3 (busy).
- R6: An update with op 0 (no operation) issues no bus request. Later captures repeat the last result and data unchanged.
- R7: A bus response with the error flag set makes the stored result 2 (failed). A read response loads its data (zero from the bench slave on error).
- R8: An update with op 3 (conditional write) issues a write only when the stored result is 0. Otherwise it issues nothing and sets the stored result to 1 (no write performed).
- R9: A bus request stays valid, with stable address and data, until the slave asserts ready.
- R10: After a synchronous reset there is no outstanding request, and the stored result, data and address are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir | input | IR_W | Current instruction code |
| capture_dr | input | 1 | Capture strobe for the selected register |
| shift_dr | input | 1 | Shift strobe, one bit per cycle |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the shift register) |
| bus_req_valid | output | 1 | Debug-bus request valid |
| bus_req_ready | input | 1 | Debug-bus request accepted |
| bus_req_addr | output | ABITS | Request address |
| bus_req_we | output | 1 | Request is a write |
| bus_req_wdata | output | 34 | Write data |
| bus_rsp_valid | input | 1 | Response valid, one cycle |
| bus_rsp_rdata | input | 34 | Response read data |
| bus_rsp_err | input | 1 | Response error flag |

## Verification
The bench first runs a fixed sequence of serial scans against a bus slave model. It then goes after the corner cases. Reads are collected one scan late: a design without the pipeline would return the wrong word. A read issued while a slow request is still outstanding must be dropped with a busy result: a design that queued or replaced the request would show an extra bus transfer or the wrong data later. A conditional write that follows a failed response must neither reach the bus nor leave the failed code in place. A request stalled by a low ready must stay valid with its address intact.

// File: rtl/dbg_xport_reg.sv
module dbg_xport_reg #(
  parameter int ABITS = 6,
  parameter int IR_W = 5,
  parameter int VERSION = 1,
  parameter logic [IR_W-1:0] IR_INFO = 5'h10,
  parameter logic [IR_W-1:0] IR_ACCESS = 5'h11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IR_W-1:0]  ir,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  output logic             tdo,
  output logic             bus_req_valid,
  input  logic             bus_req_ready,
  output logic [ABITS-1:0] bus_req_addr,
  output logic             bus_req_we,
  output logic [33:0]      bus_req_wdata,
  input  logic             bus_rsp_valid,
  input  logic [33:0]      bus_rsp_rdata,
  input  logic             bus_rsp_err
);
  localparam int LEN = ABITS + 36;
  localparam logic [1:0] OP_NOP = 2'd0, OP_COND = 2'd3;
  localparam logic [1:0] RES_OK = 2'd0, RES_NOWR = 2'd1, RES_FAIL = 2'd2, RES_BUSY = 2'd3;
  localparam logic [31:0] INFO_WORD = {24'd0, 4'(ABITS), 4'(VERSION)};

  logic [LEN-1:0] sr;
  logic           pend, busy_seen;
  logic [1:0]     res;
  logic [33:0]    rdata;

  wire             sel_info = (ir == IR_INFO);
  wire             sel_acc  = (ir == IR_ACCESS);
  wire [1:0]       up_op    = sr[1:0];
  wire [33:0]      up_data  = sr[35:2];
  wire [ABITS-1:0] up_addr  = sr[LEN-1:36];
  wire             upd      = update_dr && sel_acc;
  wire             is_req   = (up_op != OP_NOP);
  wire             cond_ok  = (up_op != OP_COND) || (res == RES_OK);
  wire             accept   = upd && is_req && !pend && cond_ok;

  assign tdo = sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
      pend <= 1'b0;
      busy_seen <= 1'b0;
      res <= RES_OK;
      rdata <= '0;
      bus_req_valid <= 1'b0;
      bus_req_addr <= '0;
      bus_req_we <= 1'b0;
      bus_req_wdata <= '0;
    end else begin
      if (capture_dr) begin
        if (sel_acc) begin
          sr <= {bus_req_addr, rdata, busy_seen ? RES_BUSY : res};
          busy_seen <= 1'b0;
        end else if (sel_info) sr <= LEN'(INFO_WORD);
        else sr <= '0;
      end else if (shift_dr) begin
        if (sel_info) sr <= LEN'({tdi, sr[31:1]});
        else sr <= {tdi, sr[LEN-1:1]};
      end

      if (accept) begin
        pend <= 1'b1;
        bus_req_valid <= 1'b1;
        bus_req_addr <= up_addr;
        bus_req_we <= up_op[1];
        bus_req_wdata <= up_data;
      end else if (upd && is_req && pend) begin
        busy_seen <= 1'b1;
      end else if (upd && !cond_ok) begin
        res <= RES_NOWR;
      end

      if (bus_req_valid && bus_req_ready) bus_req_valid <= 1'b0;

      if (bus_rsp_valid && pend) begin
        pend <= 1'b0;
        res <= bus_rsp_err ? RES_FAIL : RES_OK;
        if (!bus_req_we) rdata <= bus_rsp_rdata;
      end
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_wdata));

  assert_drop_busy_R5: assert property (@(posedge clk) disable iff (rst)
    upd && is_req && pend |=> $stable(bus_req_addr) && $stable(bus_req_wdata) && $stable(bus_req_we));

  assert_nop_idle_R6: assert property (@(posedge clk) disable iff (rst)
    upd && up_op == OP_NOP && !bus_req_valid |=> !bus_req_valid);

  assert_err_fail_R7: assert property (@(posedge clk) disable iff (rst)
    bus_rsp_valid && pend && bus_rsp_err |=> res == RES_FAIL);

  assert_cond_block_R8: assert property (@(posedge clk) disable iff (rst)
    upd && up_op == OP_COND && !pend && res != RES_OK |=> res == RES_NOWR && !$rose(bus_req_valid));

  assert_reset_R10: assert property (@(posedge clk)
    $past(rst) |-> !bus_req_valid && res == RES_OK && rdata == '0);
endmodule

// File: tb/dbg_xport_reg_test.sv
module dbg_xport_reg_test;
  localparam int ABITS = 6;
  localparam int LEN = ABITS + 36;
  localparam logic [33:0] W1 = 34'h300001234;
  localparam logic [33:0] M7 = 34'h0A0000007;
  localparam logic [33:0] W2 = 34'h200000099;
  // {op, addr, data, expected captured result, expected captured data}
  localparam logic [77:0] VEC [13] = '{
    {2'd2, 6'd5,  W1,     2'd0, 34'd0},
    {2'd1, 6'd5,  34'd0,  2'd0, 34'd0},
    {2'd0, 6'd0,  34'd0,  2'd0, W1},
    {2'd0, 6'd0,  34'd0,  2'd0, W1},
    {2'd1, 6'd63, 34'd0,  2'd0, W1},
    {2'd0, 6'd0,  34'd0,  2'd2, 34'd0},
    {2'd3, 6'd7,  34'h55, 2'd2, 34'd0},
    {2'd0, 6'd0,  34'd0,  2'd1, 34'd0},
    {2'd1, 6'd7,  34'd0,  2'd1, 34'd0},
    {2'd0, 6'd0,  34'd0,  2'd0, M7},
    {2'd3, 6'd7,  W2,     2'd0, M7},
    {2'd1, 6'd7,  34'd0,  2'd0, M7},
    {2'd0, 6'd0,  34'd0,  2'd0, W2}
  };

  logic clk = 0, rst = 1;
  logic [4:0] ir = 5'h11;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0, tdo;
  logic bus_req_valid, bus_req_we, bus_rsp_valid = 0, bus_rsp_err = 0;
  logic [ABITS-1:0] bus_req_addr;
  logic [33:0] bus_req_wdata, bus_rsp_rdata = 0;
  logic rdy = 1;
  int checks = 0, errors = 0, reqs = 0, lat = 2, cnt = 0;
  logic [33:0] mem [64];
  logic [ABITS-1:0] s_addr;
  logic s_we;
  logic [33:0] s_wdata;

  always #5 clk = ~clk;

  dbg_xport_reg uut (.clk(clk), .rst(rst), .ir(ir), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .bus_req_valid(bus_req_valid), .bus_req_ready(rdy),
    .bus_req_addr(bus_req_addr), .bus_req_we(bus_req_we), .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata), .bus_rsp_err(bus_rsp_err));

  initial for (int i = 0; i < 64; i++) mem[i] = 34'h0A0000000 + 34'(i);

  always @(posedge clk) begin
    bus_rsp_valid <= 1'b0;
    if (bus_req_valid && rdy && cnt == 0) begin
      reqs <= reqs + 1;
      s_addr <= bus_req_addr; s_we <= bus_req_we; s_wdata <= bus_req_wdata;
      cnt <= lat;
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        bus_rsp_valid <= 1'b1;
        bus_rsp_err <= (s_addr == 6'd63);
        bus_rsp_rdata <= (s_addr == 6'd63 || s_we) ? 34'd0 : mem[s_addr];
        if (s_we && s_addr != 6'd63) mem[s_addr] <= s_wdata;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic scan(logic [1:0] op, logic [ABITS-1:0] a, logic [33:0] d,
                      output logic [LEN-1:0] got);
    logic [LEN-1:0] out;
    out = {a, d, op};
    @(negedge clk) ir = 5'h11; capture_dr = 1;
    @(negedge clk) capture_dr = 0; shift_dr = 1;
    for (int i = 0; i < LEN; i++) begin
      tdi = out[i]; got[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 0; update_dr = 1;
    @(negedge clk) update_dr = 0;
    repeat (6) @(negedge clk);
  endtask

  logic done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [LEN-1:0] g;
    logic [31:0] info;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 no request after reset", 64'(bus_req_valid), 0);
    scan(2'd0, 0, 0, g);
    chk("R10 reset capture", 64'(g), 0);

    for (int k = 0; k < 13; k++) begin
      scan(VEC[k][77:76], VEC[k][75:70], VEC[k][69:36], g);
      chk($sformatf("R3/R4/R6/R7/R8 vec %0d result", k), 64'(g[1:0]), 64'(VEC[k][35:34]));
      chk($sformatf("R3/R4/R6/R7/R8 vec %0d data", k), 64'(g[35:2]), 64'(VEC[k][33:0]));
    end
    chk("R8 R6 bus request count", 64'(reqs), 6);

    lat = 300;
    scan(2'd1, 6'd9, 0, g);
    scan(2'd1, 6'd10, 0, g);
    chk("R5 accepted read not busy", 64'(g[1:0]), 0);
    scan(2'd0, 0, 0, g);
    chk("R5 dropped read reports busy", 64'(g[1:0]), 3);
    chk("R5 dropped read issues nothing", 64'(reqs), 7);
    repeat (350) @(negedge clk);
    scan(2'd0, 0, 0, g);
    chk("R5 result after completion", 64'(g[1:0]), 0);
    chk("R5 data of accepted read", 64'(g[35:2]), 64'(34'h0A0000009));
    chk("R2 captured address", 64'(g[LEN-1:36]), 9);

    lat = 2; rdy = 0;
    scan(2'd2, 6'd12, 34'h100000042, g);
    repeat (20) @(negedge clk);
    chk("R9 request held", 64'(bus_req_valid), 1);
    chk("R9 address held", 64'(bus_req_addr), 12);
    chk("R4 flags in write data", 64'(bus_req_wdata), 64'(34'h100000042));
    rdy = 1;
    repeat (10) @(negedge clk);
    scan(2'd1, 6'd12, 0, g);
    scan(2'd0, 0, 0, g);
    chk("R4 written word read back", 64'(g[35:2]), 64'(34'h100000042));

    @(negedge clk) ir = 5'h10; capture_dr = 1;
    @(negedge clk) capture_dr = 0; shift_dr = 1;
    for (int i = 0; i < 32; i++) begin
      info[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 0;
    chk("R1 info word", 64'(info), 64'h61);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule